// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host read and write an external asynchronous static RAM of 131072 bytes. The RAM has one shared bidirectional byte bus. The host side uses a valid/ready request handshake. Each request carries a write flag, a 17-bit address and a byte of write data. Read results come back on a registered data port, marked by a single-cycle valid pulse. The memory side drives active-low chip select, output enable and write enable, plus the address, and controls a three-state driver on the byte bus. The memory is fully static, so the block issues no clock and no refresh to it.

Every access phase lasts a whole number of clock cycles. The block works these counts out at elaboration from the clock period and the memory's nanosecond minimums, rounding up. Output enable stays high for the whole of every write, so the shorter write-pulse minimum applies. A write that follows a read waits through idle turnaround cycles first. This gives the memory's outputs time to float before the controller drives the bus. With a 100 MHz clock the defaults are:
- a 2-cycle read,
- a 1-cycle write setup,
- a 1-cycle write pulse,
- a 1-cycle turnaround.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low) and on the first cycle after it, chip select, output enable and write enable are all high, the bus driver is off, the ready output is high and the read-valid output is low.
- R2: A request is taken on a clock edge where both the request valid and the ready output are high. Ready stays low from that edge until the access has released its strobes.
- R3: A read holds chip select and output enable low, with write enable high, for RD_CYC cycles. On the last of these cycles the block samples the bus. The sampled byte appears on the read data output, with read valid high, in the cycle after the strobes go back high.
- R4: A write holds chip select low and output enable high throughout. It spends WSET_CYC cycles with write enable high, then WP_CYC cycles with write enable low while driving the write byte. It then returns all strobes high.
- R5: Output enable and write enable are never low at the same time. The controller drives the bus only while write enable is low and output enable is high.
- R6: If the previous completed access was a read, an accepted write first spends TURN_CYC cycles with all strobes high and ready low. Only then does chip select fall.
- R7: If the previous completed access was a write, or there has been no access since reset, chip select falls in the first cycle after acceptance. There are no turnaround cycles.
- R8: The memory address equals the accepted request address and does not change while chip select is low.
- R9: The cycle counts are ceiling divisions of the timing parameters by the clock period. RD_CYC is the larger of (access time rounded up + 1) and the read cycle time rounded up. WP_CYC is at least 1. WSET_CYC is the write cycle time rounded up minus WP_CYC, at least 1. TURN_CYC is the float time rounded up, at least 1. The defaults give 2, 1, 1 and 1.
- R10: Read valid is high for exactly one cycle per read. Read data keeps its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a fresh read result |
| rd_data | output | 8 | Read result |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq | inout | 8 | Shared three-state data bus |

## Verification
The bench models the memory with a zero-delay behavioural array. It issues random and directed mixes of reads and writes, and checks the strobe pattern in every cycle of each access.

The corner cases it targets are:
- Write after read. A design that skips the turnaround would drop chip select at once and drive the bus too early.
- Write after write. A design that always adds turnaround would show a stray idle cycle.
- Read of a just-written address. A wrong capture cycle or a bad write strobe would return stale data.
- A read-valid pulse that lasts more than one cycle.
- An address that moves while chip select is low.
- Output enable and write enable overlapping, which would let both sides drive the bus.

// File: rtl/sramc_pkg.sv
// Shared types and elaboration-time helpers for the SRAM controller.
// Assumes all timing values are integer picoseconds.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WSET,
        ST_WPUL
    } sramc_state_e;

    // Ceiling division used to turn a time into whole clock cycles.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_seq.sv
// Access sequencer: steps each accepted request through its phases and
// drives the active-low strobes and the bus-driver enable from registers.
// Assumes the phase lengths given are all at least one cycle.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int RD_CYC   = 2,
    parameter int WSET_CYC = 1,
    parameter int WP_CYC   = 1,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic load,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drv_en
);

    sramc_state_e     st;
    logic [CNT_W-1:0] cnt;
    logic             last_rd;
    logic             cnt_done;

    assign req_ready = (st == ST_IDLE);
    assign load      = req_valid && req_ready;
    assign cnt_done  = (cnt == '0);
    assign capture   = (st == ST_READ) && cnt_done;

    // Phase state, phase counter and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            drv_en  <= 1'b0;
            last_rd <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!req_write) begin
                            st   <= ST_READ;
                            cnt  <= CNT_W'(RD_CYC - 1);
                            ce_n <= 1'b0;
                            oe_n <= 1'b0;
                        end else if (last_rd) begin
                            st  <= ST_TURN;
                            cnt <= CNT_W'(TURN_CYC - 1);
                        end else begin
                            st   <= ST_WSET;
                            cnt  <= CNT_W'(WSET_CYC - 1);
                            ce_n <= 1'b0;
                        end
                    end
                end
                ST_TURN: begin
                    if (cnt_done) begin
                        st   <= ST_WSET;
                        cnt  <= CNT_W'(WSET_CYC - 1);
                        ce_n <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt_done) begin
                        st      <= ST_IDLE;
                        ce_n    <= 1'b1;
                        oe_n    <= 1'b1;
                        last_rd <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WSET: begin
                    if (cnt_done) begin
                        st     <= ST_WPUL;
                        cnt    <= CNT_W'(WP_CYC - 1);
                        we_n   <= 1'b0;
                        drv_en <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WPUL: begin
                    if (cnt_done) begin
                        st      <= ST_IDLE;
                        we_n    <= 1'b1;
                        ce_n    <= 1'b1;
                        drv_en  <= 1'b0;
                        last_rd <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Checker-only counter of consecutive write-enable-low cycles.
    logic [CNT_W-1:0] we_run;
    always_ff @(posedge clk) begin
        if (!rst_n)     we_run <= '0;
        else if (!we_n) we_run <= we_run + 1'b1;
        else            we_run <= '0;
    end

    // R5
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R5
    drive_only_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!we_n && oe_n));

    // R4
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run == CNT_W'(WP_CYC)));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !req_ready);

    // R4
    strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> !ce_n);

endmodule

// File: rtl/sramc_io.sv
// Datapath: holds address and write byte for the access, drives the
// three-state bus and registers the read result. Assumes load is only
// raised while no access is in progress.
module sramc_io #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              drv_en,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    inout  wire  [DATA_W-1:0] mem_dq
);

    logic [DATA_W-1:0] wdata_q;

    assign mem_dq = drv_en ? wdata_q : {DATA_W{1'bz}};

    // Latch request address and write byte on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
        end else if (load) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    // Sample the bus on the last read cycle and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq;
        end
    end

    // R10
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));

    // R10
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

// File: rtl/sram_ctrl.sv
// Top of the asynchronous SRAM controller. Converts the memory's timing
// minimums into whole clock cycles and connects sequencer and datapath.
// Assumes one clock domain and an external memory with a shared byte bus.
module sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CLK_PS = 10000,
    parameter int T_ACC_PS = 10000,
    parameter int T_RCYC_PS = 10000,
    parameter int T_WCYC_PS = 10000,
    parameter int T_WPUL_PS = 7000,
    parameter int T_FLOAT_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int RD_CYC   = imax(cdiv(T_ACC_PS, CLK_PS) + 1, cdiv(T_RCYC_PS, CLK_PS));
    localparam int WP_CYC   = imax(1, cdiv(T_WPUL_PS, CLK_PS));
    localparam int WSET_CYC = imax(1, cdiv(T_WCYC_PS, CLK_PS) - WP_CYC);
    localparam int TURN_CYC = imax(1, cdiv(T_FLOAT_PS, CLK_PS));
    localparam int CNT_W    = $clog2(imax(imax(RD_CYC, WP_CYC), imax(WSET_CYC, TURN_CYC)) + 1) + 1;

    logic load;
    logic capture;
    logic drv_en;

    sramc_seq #(
        .RD_CYC  (RD_CYC),
        .WSET_CYC(WSET_CYC),
        .WP_CYC  (WP_CYC),
        .TURN_CYC(TURN_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .load     (load),
        .capture  (capture),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .drv_en   (drv_en)
    );

    sramc_io #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .capture  (capture),
        .drv_en   (drv_en),
        .ce_n     (mem_ce_n),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .mem_addr (mem_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .mem_dq   (mem_dq)
    );

    // R6
    no_capture_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !drv_en);

endmodule

// File: tb/sram_ctrl_bench.sv
// Self-checking bench: behavioural memory model, directed corner cases
// and seeded random traffic, with per-cycle strobe checks.
module sram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RD   = 2;
    localparam int WSET = 1;
    localparam int WP   = 1;
    localparam int TURN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [16:0] mem_addr;
    wire  [7:0]  mem_dq;

    int checks = 0;
    int errors = 0;
    bit last_rd = 1'b0;
    logic [7:0] marr [256];
    logic [7:0] refm [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_ctrl u_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq)
    );

    // Memory model: drives on read strobes, stores mid-cycle while written.
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? marr[mem_addr[7:0]] : 8'bz;
    always @(negedge clk) if (!mem_ce_n && !mem_we_n) marr[mem_addr[7:0]] <= mem_dq;

    function automatic void chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endfunction

    function automatic int strobes();
        return {mem_ce_n, mem_oe_n, mem_we_n};
    endfunction

    // R5: checked on every cycle out of reset.
    always @(negedge clk) if (rst_n)
        chk(!(!mem_oe_n && !mem_we_n), "R5", strobes(), 3'b111);

    task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
        chk(req_ready == 1'b1, "R2", req_ready, 1);
        chk(rd_valid == 1'b0, "R10", rd_valid, 0);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = $urandom_range(1); req_addr = 17'($urandom);
        req_wdata = 8'($urandom);
        if (!wr) begin
            for (int i = 0; i < RD; i++) begin
                chk(strobes() == 3'b001, "R3 R9", strobes(), 3'b001);
                chk(mem_addr == a, "R8", mem_addr, a);
                chk(!req_ready, "R2", req_ready, 0);
                chk(!rd_valid, "R10", rd_valid, 0);
                @(negedge clk);
            end
            chk(rd_valid && rd_data == refm[a[7:0]], "R3", rd_data, refm[a[7:0]]);
            chk(strobes() == 3'b111, "R3", strobes(), 3'b111);
            begin
                logic [7:0] held;
                held = rd_data;
                @(negedge clk);
                chk(!rd_valid, "R10", rd_valid, 0);
                chk(rd_data == held, "R10", rd_data, held);
            end
            last_rd = 1'b1;
        end else begin
            if (last_rd) begin
                for (int i = 0; i < TURN; i++) begin
                    chk(strobes() == 3'b111 && !req_ready, "R6", strobes(), 3'b111);
                    @(negedge clk);
                end
            end else begin
                chk(mem_ce_n == 1'b0, "R7", mem_ce_n, 0);
            end
            for (int i = 0; i < WSET; i++) begin
                chk(strobes() == 3'b011, "R4 R9", strobes(), 3'b011);
                chk(mem_addr == a, "R8", mem_addr, a);
                chk(!req_ready, "R2", req_ready, 0);
                @(negedge clk);
            end
            for (int i = 0; i < WP; i++) begin
                chk(strobes() == 3'b010, "R4 R9", strobes(), 3'b010);
                chk(mem_dq === d, "R4", mem_dq, d);
                chk(mem_addr == a, "R8", mem_addr, a);
                @(negedge clk);
            end
            chk(strobes() == 3'b111 && req_ready, "R4", strobes(), 3'b111);
            refm[a[7:0]] = d;
            last_rd = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) begin
            marr[i] = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk(strobes() == 3'b111, "R1", strobes(), 3'b111);
        chk(!rd_valid, "R1", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(strobes() == 3'b111 && req_ready && !rd_valid, "R1", strobes(), 3'b111);
        // Directed: first write (R7), write-write, read-back, read-read,
        // write after read (R6), extreme addresses.
        run_op(1'b1, 17'h00000, 8'hA5);
        run_op(1'b1, 17'h1FFFF, 8'h3C);
        run_op(1'b0, 17'h00000, 8'h00);
        run_op(1'b0, 17'h1FFFF, 8'h00);
        run_op(1'b1, 17'h00012, 8'h77);
        run_op(1'b0, 17'h00012, 8'h00);
        run_op(1'b1, 17'h00012, 8'h88);
        run_op(1'b0, 17'h00012, 8'h00);
        // Seeded random traffic with idle gaps.
        for (int n = 0; n < 400; n++) begin
            run_op(1'($urandom_range(1)), 17'($urandom), 8'($urandom));
            for (int g = $urandom_range(2); g > 0; g--) begin
                chk(req_ready && strobes() == 3'b111, "R2", strobes(), 3'b111);
                @(negedge clk);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule